// File: doc/BRIEF.md
# SDRAM Write Burst Termination Sequencer

This controller-side block runs one SDRAM write to a single bank and ends it early with an explicit precharge instead of an auto-precharge. A request carries a bank, a row, a column, a beat count and the data beats. The block presents a WRITE carrying the first beat, streams the other beats on the following cycles, and then holds NOP until the write-recovery time has passed. It then presents PRECHARGE, waits out the precharge time with more NOPs, and presents ACTIVATE for the requested row.

While the device's programmed burst is still running past the last valid beat, the block asserts the data-mask lines so that no stale data reaches the array. The mask starts on the cycle after the last valid beat and ends on the precharge cycle. Write-recovery and precharge times are given in picoseconds together with the clock period. The block converts each of them into a cycle count by rounding up, with a floor of one cycle.

Top module: `sdram_wrterm_seq`

## Requirements
- R1: On the cycle after a request is accepted (req_valid high while ready is high), the command pins carry WRITE ({ras_n,cas_n,we_n} = 3'b100) with the latched bank on sd_ba, the column zero-extended on sd_addr (bit 10 low, so no auto-precharge), and beat 0 on sd_dq_out.
- R2: With req_len = beats-1, beat k is driven on sd_dq_out with sd_dq_oe high in cycle k after WRITE (cycle 0 is the WRITE), for k = 0..req_len. sd_dq_oe is low in every other cycle.
- R3: PRECHARGE ({ras_n,cas_n,we_n} = 3'b010, sd_addr = 0 so bit 10 is low, latched bank on sd_ba) is issued WR_CYC cycles after the cycle of the last beat. WR_CYC = ceil(T_WR_PS / T_CK_PS), with a minimum of 1.
- R4: sd_dqm has all bits high in each cycle k with req_len < k <= req_len+WR_CYC and k < BURST_LEN. In every other cycle, including idle, sd_dqm is all low.
- R5: ACTIVATE ({ras_n,cas_n,we_n} = 3'b011, row on sd_addr, latched bank on sd_ba) is issued RP_CYC cycles after PRECHARGE. RP_CYC = ceil(T_RP_PS / T_CK_PS), with a minimum of 1.
- R6: Every cycle other than the WRITE, PRECHARGE and ACTIVATE cycles carries NOP (3'b111), including idle cycles. sd_addr is 0 on those cycles.
- R7: done is high for exactly the ACTIVATE cycle.
- R8: ready is high only when the block is idle. A request presented while ready is low is ignored: the running sequence is unchanged and no WRITE follows it.
- R9: While rst_n is low, ready is high, the command is NOP, and sd_dq_oe, sd_dqm and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to activate after the precharge |
| req_col | input | COL_W | Start column |
| req_len | input | LEN_W | Number of valid beats minus one |
| req_data | input | BURST_LEN*DQ_W | Beats, beat 0 in the low bits |
| ready | output | 1 | Idle, a request will be taken |
| done | output | 1 | Pulse on the ACTIVATE cycle |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| sd_dq_out | output | DQ_W | Write data |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dqm | output | DQ_W/8 | Data mask, one bit per byte |

## Verification
The assertions take for granted that the requester samples ready before it raises req_valid. They also assume that req_len never exceeds BURST_LEN-1, and that rst_n is held low for at least one clock before the first request. The stimulus raises requests only at a falling edge, and always holds reset for several cycles first. It sweeps every legal length across several bank, row, column and data patterns. On alternate passes it keeps req_valid high with different fields for the whole busy period, so that requests arriving while ready is low are exercised without breaking any of these assumptions.

// File: rtl/sdram_wrterm_seq.sv
module sdram_wrterm_seq #(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int ADDR_W    = 12,
  parameter int DQ_W      = 16,
  parameter int BURST_LEN = 4,
  parameter int T_CK_PS   = 10000,
  parameter int T_WR_PS   = 15000,
  parameter int T_RP_PS   = 18000,
  localparam int LEN_W    = $clog2(BURST_LEN),
  localparam int DQM_W    = DQ_W / 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [BANK_W-1:0]         req_bank,
  input  logic [ROW_W-1:0]          req_row,
  input  logic [COL_W-1:0]          req_col,
  input  logic [LEN_W-1:0]          req_len,
  input  logic [BURST_LEN*DQ_W-1:0] req_data,
  output logic                      ready,
  output logic                      done,
  output logic                      sd_ras_n,
  output logic                      sd_cas_n,
  output logic                      sd_we_n,
  output logic [BANK_W-1:0]         sd_ba,
  output logic [ADDR_W-1:0]         sd_addr,
  output logic [DQ_W-1:0]           sd_dq_out,
  output logic                      sd_dq_oe,
  output logic [DQM_W-1:0]          sd_dqm
);

  localparam int WR_RAW = (T_WR_PS + T_CK_PS - 1) / T_CK_PS;
  localparam int RP_RAW = (T_RP_PS + T_CK_PS - 1) / T_CK_PS;
  localparam int WR_CYC = (WR_RAW < 1) ? 1 : WR_RAW;
  localparam int RP_CYC = (RP_RAW < 1) ? 1 : RP_RAW;
  localparam int CNT_W  = $clog2(BURST_LEN + WR_CYC + RP_CYC + 1);

  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_WR  = 3'b100;
  localparam logic [2:0] CMD_PRE = 3'b010;
  localparam logic [2:0] CMD_ACT = 3'b011;

  logic              busy;
  logic [CNT_W-1:0]  cyc;
  logic [LEN_W-1:0]  len_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DQ_W-1:0]   beat_q [BURST_LEN];

  logic [CNT_W-1:0]  last_at, pre_at, act_at;
  logic              is_wr, is_pre, is_act, in_data, in_mask;
  logic [2:0]        cmd;

  assign last_at = CNT_W'(len_q);
  assign pre_at  = last_at + CNT_W'(WR_CYC);
  assign act_at  = pre_at + CNT_W'(RP_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cyc    <= '0;
      len_q  <= '0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy   <= 1'b1;
        cyc    <= '0;
        len_q  <= req_len;
        bank_q <= req_bank;
        row_q  <= req_row;
        col_q  <= req_col;
      end
    end else if (cyc == act_at) begin
      busy <= 1'b0;
      cyc  <= '0;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  for (genvar b = 0; b < BURST_LEN; b++) begin : g_beat
    always_ff @(posedge clk) begin
      if (!rst_n)                 beat_q[b] <= '0;
      else if (!busy && req_valid) beat_q[b] <= req_data[b*DQ_W +: DQ_W];
    end
  end

  assign is_wr   = busy && (cyc == '0);
  assign is_pre  = busy && (cyc == pre_at);
  assign is_act  = busy && (cyc == act_at);
  assign in_data = busy && (cyc <= last_at);
  assign in_mask = busy && (cyc > last_at) && (cyc <= pre_at)
                   && (cyc < CNT_W'(BURST_LEN));

  always_comb begin
    cmd     = CMD_NOP;
    sd_addr = '0;
    if (is_wr) begin
      cmd     = CMD_WR;
      sd_addr = ADDR_W'(col_q);
    end else if (is_pre) begin
      cmd     = CMD_PRE;
    end else if (is_act) begin
      cmd     = CMD_ACT;
      sd_addr = ADDR_W'(row_q);
    end
  end

  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_ba     = busy ? bank_q : '0;
  assign sd_dq_oe  = in_data;
  assign sd_dq_out = in_data ? beat_q[cyc[LEN_W-1:0]] : '0;
  assign sd_dqm    = in_mask ? '1 : '0;
  assign ready     = !busy;
  assign done      = is_act;

endmodule

// File: rtl/sdram_wrterm_chk.sv
module sdram_wrterm_chk #(
  parameter int DQM_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             ready,
  input logic             done,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic             sd_dq_oe,
  input logic [DQM_W-1:0] sd_dqm
);

  logic [2:0] cmd;
  assign cmd = {sd_ras_n, sd_cas_n, sd_we_n};

  // R1
  write_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> (cmd == 3'b100));

  // R8
  write_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b100) |-> $past(ready && req_valid));

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> !ready);

  // R7
  done_on_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd == 3'b011));

  // R7
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready);

  // R4
  mask_follows_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|sd_dqm) |-> $past(sd_dq_oe));

  // R4
  mask_not_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sd_dqm) |-> !sd_dq_oe);

  // R3
  pre_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b010) |-> (!sd_dq_oe && !ready));

endmodule

bind sdram_wrterm_seq sdram_wrterm_chk #(.DQM_W(DQM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready), .done(done),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm)
);

// File: tb/sim_sdram_wrterm_seq.sv
module sim_sdram_wrterm_seq;
  localparam int CLK_NS  = 10;
  localparam int BANK_W  = 2;
  localparam int ROW_W   = 12;
  localparam int COL_W   = 8;
  localparam int ADDR_W  = 12;
  localparam int DQ_W    = 16;
  localparam int BL      = 4;
  localparam int TCK     = 10000;
  localparam int TWR     = 15000;
  localparam int TRP     = 18000;
  localparam int LEN_W   = $clog2(BL);
  localparam int DQM_W   = DQ_W / 8;
  localparam int M_EXP   = ((TWR + TCK - 1) / TCK < 1) ? 1 : (TWR + TCK - 1) / TCK;
  localparam int RP_EXP  = ((TRP + TCK - 1) / TCK < 1) ? 1 : (TRP + TCK - 1) / TCK;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [BL*DQ_W-1:0] req_data = '0;
  logic ready, done, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [BANK_W-1:0] sd_ba;
  logic [ADDR_W-1:0] sd_addr;
  logic [DQ_W-1:0]   sd_dq_out;
  logic [DQM_W-1:0]  sd_dqm;

  int total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  sdram_wrterm_seq #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .DQ_W(DQ_W),
    .BURST_LEN(BL), .T_CK_PS(TCK), .T_WR_PS(TWR), .T_RP_PS(TRP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_len(req_len), .req_data(req_data),
    .ready(ready), .done(done), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DQ_W-1:0] beat(input int pat, input int len, input int k);
    return DQ_W'((pat << 12) | (len << 8) | (k + 8'h30));
  endfunction

  task automatic run_txn(input int len, input int pat, input bit junk);
    int pre_k, act_k;
    logic [2:0] ecmd;
    logic [ADDR_W-1:0] eaddr;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    pre_k = len + M_EXP;
    act_k = pre_k + RP_EXP;
    bank = BANK_W'(pat);
    row  = ROW_W'(12'h5A0 + pat * 37 + len);
    col  = COL_W'(8'h11 * (pat + 1) + len);
    @(negedge clk);
    chk(ready == 1'b1, "R8 ready when idle", 32'(ready), 1);
    req_bank = bank; req_row = row; req_col = col; req_len = LEN_W'(len);
    for (int b = 0; b < BL; b++) req_data[b*DQ_W +: DQ_W] = beat(pat, len, b);
    req_valid = 1'b1;
    @(negedge clk);
    if (junk) begin
      req_bank = ~bank; req_row = ~row; req_col = ~col; req_len = '0;
      req_data = ~req_data;
    end else begin
      req_valid = 1'b0;
    end
    for (int k = 0; k <= act_k; k++) begin
      if (k == 0)          ecmd = 3'b100;
      else if (k == pre_k) ecmd = 3'b010;
      else if (k == act_k) ecmd = 3'b011;
      else                 ecmd = 3'b111;
      eaddr = (k == 0) ? ADDR_W'(col) : (k == act_k) ? ADDR_W'(row) : '0;
      chk({sd_ras_n, sd_cas_n, sd_we_n} == ecmd,
          (k == 0) ? "R1 write cmd" : (k == pre_k) ? "R3 precharge timing" :
          (k == act_k) ? "R5 activate timing" : "R6 nop between", 32'({sd_ras_n, sd_cas_n, sd_we_n}), 32'(ecmd));
      chk(sd_addr == eaddr, (k == 0) ? "R1 column addr a10 low" : (k == act_k) ? "R5 row addr" : "R3 R6 addr zero",
          32'(sd_addr), 32'(eaddr));
      chk(sd_ba == bank, "R1 R3 R5 bank", 32'(sd_ba), 32'(bank));
      chk(sd_dq_oe == (k <= len), "R2 output enable", 32'(sd_dq_oe), 32'(k <= len));
      if (k <= len)
        chk(sd_dq_out == beat(pat, len, k), "R2 beat data", 32'(sd_dq_out), 32'(beat(pat, len, k)));
      chk(sd_dqm == ((k > len && k <= pre_k && k < BL) ? '1 : '0), "R4 mask window",
          32'(sd_dqm), 32'((k > len && k <= pre_k && k < BL) ? {DQM_W{1'b1}} : '0));
      chk(done == (k == act_k), "R7 done pulse", 32'(done), 32'(k == act_k));
      chk(ready == 1'b0, "R8 ready low while busy", 32'(ready), 0);
      if (k == act_k) req_valid = 1'b0;
      @(negedge clk);
    end
    for (int i = 0; i < 2; i++) begin
      chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R8 no write from ignored request",
          32'({sd_ras_n, sd_cas_n, sd_we_n}), 32'h7);
      chk(ready == 1'b1 && done == 1'b0 && sd_dqm == '0, "R6 R7 idle after activate",
          32'({ready, done}), 32'h2);
      if (i == 0) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R9 ready in reset", 32'(ready), 1);
    chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R9 nop in reset", 32'({sd_ras_n, sd_cas_n, sd_we_n}), 32'h7);
    chk(!sd_dq_oe && sd_dqm == '0 && !done, "R9 outputs low in reset", 32'({sd_dq_oe, done}), 0);
    rst_n = 1'b1;
    for (int len = 0; len < BL; len++)
      for (int pat = 0; pat < 4; pat++)
        run_txn(len, pat, pat[0]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule